// File: doc/BRIEF.md
# Address-Error Exception Frame Sequencer

This block carries out the bus side of an address-error trap for a 16-bit-bus processor core. One start pulse makes it take a snapshot of the program counter, status register, instruction word, faulting address, access-status word and supervisor stack pointer. It then writes a seven-word (14-byte) frame below the old stack pointer, reads the 32-bit handler address from the trap vector at byte address 12, and refills a two-word prefetch queue from the handler address.

Every bus access lasts exactly four clocks with no wait states. The memory side must return read data on `bus_rdata`, which is sampled on the fourth clock of a read. The bus has a fixed timing, so there is no valid/ready handshake and no back-pressure. `start` and `busy` are plain control pins. A whole sequence lasts 50 clocks: four idle clocks, seven stack writes, two vector reads, one prefetch read, two idle clocks and a second prefetch read. The status register value is only copied into the frame and is never altered.

Top module: `ae_frame_seq`

## Requirements
- R1: A `start` pulse sampled while `busy` is low makes `busy` high from the next clock. `busy` stays high for exactly 50 clocks and then falls.
- R2: During the first 4 busy clocks `bus_act` is low.
- R3: Seven word writes follow, in this order. The byte offsets are below the stack pointer captured at start. PC bits 15:0 go to -2, SR to -6, PC bits 31:16 to -4, the instruction word to -8, fault address bits 15:0 to -10, the status word to -14, and fault address bits 31:16 to -12.
- R4: Each access holds `bus_act` high for 4 consecutive clocks, with address, direction and write data unchanged during them. Stack writes and vector reads carry `bus_fc` = 5 (data). `bus_wr` is 1 for writes and 0 for reads.
- R5: Two vector reads follow the writes: the high word from byte address 12, then the low word from byte address 14. From the clock after the second read, `pc_out` equals {high, low}.
- R6: Next comes a read at `pc_out`, then 2 clocks with `bus_act` low, then a read at `pc_out`+2 (modulo 2^32). Both reads carry `bus_fc` = 6 (program). The two words read appear on `pf_word0` and `pf_word1` once `busy` has fallen.
- R7: From the clock after an accepted start, `ssp_out` equals the captured stack pointer minus 14 (modulo 2^32).
- R8: A `start` pulse while `busy` is high is ignored. The running sequence, its bus accesses and all outputs continue as if it had not occurred.
- R9: In reset and whenever `busy` is low, `bus_act` is 0. After reset `ssp_out`, `pc_out`, `pf_word0` and `pf_word1` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trap request pulse |
| pc_in | input | 32 | Program counter to stack |
| sr_in | input | 16 | Status register to stack |
| ir_in | input | 16 | Instruction word to stack |
| fault_addr | input | 32 | Faulting access address |
| stat_word | input | 16 | Access-status / function-code word to stack |
| ssp_in | input | 32 | Supervisor stack pointer before the trap |
| bus_rdata | input | 16 | Read data, sampled on the last clock of a read |
| busy | output | 1 | Sequence in progress |
| bus_act | output | 1 | Bus access in progress |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the word access |
| bus_wdata | output | 16 | Write data |
| bus_fc | output | 3 | Function code: 5 data, 6 program |
| ssp_out | output | 32 | Updated stack pointer |
| pc_out | output | 32 | Handler program counter |
| pf_word0 | output | 16 | First prefetch word |
| pf_word1 | output | 16 | Second prefetch word |

## Verification
The main function is tried with four stimulus sets. The first is a realistic trap with a small stack pointer and a low handler address. The second has a stack pointer of 12, so the frame wraps below zero, and a handler of 0xFFFFFFFE, so the second prefetch wraps to 0; this separates correct modulo arithmetic from clipped or sign-confused offsets. The third sends a second start pulse with changed inputs in mid-sequence, which shows whether a re-latch or restart leaks into the bus stream or the outputs. The fourth starts a run right after the previous one ends, which exposes state left over from the earlier run. Memory returns address-dependent words, so a wrong read slot or a swapped prefetch word shows up as a data mismatch.

// File: rtl/ae_frame_pkg.sv
package ae_frame_pkg;

  localparam int FRAME_WORDS = 7;
  localparam int VEC_READS   = 2;
  localparam int FETCH_READS = 2;
  localparam int TOTAL_ACC   = FRAME_WORDS + VEC_READS + FETCH_READS;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_STACK,
    ACC_VECTOR,
    ACC_FETCH
  } acc_kind_e;

  // Byte offset of each frame write, measured up from the new stack pointer.
  // The write order is fixed behaviour.
  function automatic logic [3:0] frame_offset(input logic [3:0] slot);
    case (slot)
      4'd0:    frame_offset = 4'd12;
      4'd1:    frame_offset = 4'd8;
      4'd2:    frame_offset = 4'd10;
      4'd3:    frame_offset = 4'd6;
      4'd4:    frame_offset = 4'd4;
      4'd5:    frame_offset = 4'd0;
      4'd6:    frame_offset = 4'd2;
      default: frame_offset = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/ae_seq_timer.sv
module ae_seq_timer #(
  parameter int TOTAL = 50,
  parameter int SW    = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          finish
);

  localparam logic [SW-1:0] LAST = SW'(TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == LAST) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign finish = busy && (step == LAST);

endmodule

// File: rtl/ae_bus_plan.sv
module ae_bus_plan
  import ae_frame_pkg::*;
#(
  parameter int ACC_CLKS = 4,
  parameter int IDLE_PRE = 4,
  parameter int IDLE_MID = 2,
  parameter int SW       = 6
) (
  input  logic          busy,
  input  logic [SW-1:0] step,
  output acc_kind_e     kind,
  output logic [3:0]    slot,
  output logic          beat_last
);

  // Accesses before the mid-sequence idle gap.
  localparam int SPAN_A  = (TOTAL_ACC - 1) * ACC_CLKS;
  localparam int LAST_AT = SPAN_A + IDLE_MID;

  always_comb begin
    int s;
    int acc;
    kind      = ACC_IDLE;
    slot      = '0;
    beat_last = 1'b0;
    acc       = -1;
    s         = int'(step) - IDLE_PRE;
    if (busy && s >= 0) begin
      if (s < SPAN_A) begin
        acc       = s / ACC_CLKS;
        beat_last = (s % ACC_CLKS) == ACC_CLKS - 1;
      end else if (s >= LAST_AT && s < LAST_AT + ACC_CLKS) begin
        acc       = TOTAL_ACC - 1;
        beat_last = (s - LAST_AT) == ACC_CLKS - 1;
      end
    end
    if (acc >= 0) begin
      slot = 4'(acc);
      if (acc < FRAME_WORDS)                  kind = ACC_STACK;
      else if (acc < FRAME_WORDS + VEC_READS) kind = ACC_VECTOR;
      else                                    kind = ACC_FETCH;
    end
  end

endmodule

// File: rtl/ae_frame_mux.sv
module ae_frame_mux
  import ae_frame_pkg::*;
#(
  parameter int                AW       = 32,
  parameter int                DW       = 16,
  parameter int                FCW      = 3,
  parameter logic [AW-1:0]     VEC_BASE = 32'd12,
  parameter logic [FCW-1:0]    FC_DATA  = 3'd5,
  parameter logic [FCW-1:0]    FC_PROG  = 3'd6
) (
  input  acc_kind_e        kind,
  input  logic [3:0]       slot,
  input  logic [AW-1:0]    pc_snap,
  input  logic [DW-1:0]    sr_snap,
  input  logic [DW-1:0]    ir_snap,
  input  logic [AW-1:0]    fa_snap,
  input  logic [DW-1:0]    st_snap,
  input  logic [AW-1:0]    ssp_new,
  input  logic [AW-1:0]    pc_cur,
  output logic             act,
  output logic             wr,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    wdata,
  output logic [FCW-1:0]   fc
);

  localparam logic [3:0] VEC_LO_SLOT = 4'(FRAME_WORDS + 1);
  localparam logic [3:0] PF_HI_SLOT  = 4'(TOTAL_ACC - 1);

  always_comb begin
    act   = 1'b0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    fc    = '0;
    case (kind)
      ACC_STACK: begin
        act  = 1'b1;
        wr   = 1'b1;
        fc   = FC_DATA;
        addr = ssp_new + AW'(frame_offset(slot));
        case (slot)
          4'd0:    wdata = pc_snap[DW-1:0];
          4'd1:    wdata = sr_snap;
          4'd2:    wdata = pc_snap[2*DW-1:DW];
          4'd3:    wdata = ir_snap;
          4'd4:    wdata = fa_snap[DW-1:0];
          4'd5:    wdata = st_snap;
          4'd6:    wdata = fa_snap[2*DW-1:DW];
          default: wdata = '0;
        endcase
      end
      ACC_VECTOR: begin
        act  = 1'b1;
        fc   = FC_DATA;
        addr = VEC_BASE + ((slot == VEC_LO_SLOT) ? AW'(2) : AW'(0));
      end
      ACC_FETCH: begin
        act  = 1'b1;
        fc   = FC_PROG;
        addr = pc_cur + ((slot == PF_HI_SLOT) ? AW'(2) : AW'(0));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ae_frame_seq.sv
module ae_frame_seq
  import ae_frame_pkg::*;
#(
  parameter int             AW       = 32,
  parameter int             DW       = 16,
  parameter int             FCW      = 3,
  parameter int             ACC_CLKS = 4,
  parameter int             IDLE_PRE = 4,
  parameter int             IDLE_MID = 2,
  parameter logic [AW-1:0]  VEC_BASE = 32'd12,
  parameter logic [FCW-1:0] FC_DATA  = 3'd5,
  parameter logic [FCW-1:0] FC_PROG  = 3'd6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  pc_in,
  input  logic [DW-1:0]  sr_in,
  input  logic [DW-1:0]  ir_in,
  input  logic [AW-1:0]  fault_addr,
  input  logic [DW-1:0]  stat_word,
  input  logic [AW-1:0]  ssp_in,
  input  logic [DW-1:0]  bus_rdata,
  output logic           busy,
  output logic           bus_act,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  output logic [FCW-1:0] bus_fc,
  output logic [AW-1:0]  ssp_out,
  output logic [AW-1:0]  pc_out,
  output logic [DW-1:0]  pf_word0,
  output logic [DW-1:0]  pf_word1
);

  localparam int FRAME_BYTES = FRAME_WORDS * DW / 8;
  localparam int TOTAL_CLKS  = IDLE_PRE + TOTAL_ACC * ACC_CLKS + IDLE_MID;
  localparam int SW          = $clog2(TOTAL_CLKS + 1);
  localparam int FETCH_FROM  = IDLE_PRE + (FRAME_WORDS + VEC_READS) * ACC_CLKS;

  localparam logic [3:0] VEC_HI_SLOT = 4'(FRAME_WORDS);
  localparam logic [3:0] VEC_LO_SLOT = 4'(FRAME_WORDS + 1);
  localparam logic [3:0] PF_LO_SLOT  = 4'(FRAME_WORDS + VEC_READS);
  localparam logic [3:0] PF_HI_SLOT  = 4'(TOTAL_ACC - 1);

  logic          launch;
  logic [SW-1:0] step;
  logic          finish;
  acc_kind_e     kind;
  logic [3:0]    slot;
  logic          beat_last;

  logic [AW-1:0] pc_q, fa_q, ssp_q;
  logic [DW-1:0] sr_q, ir_q, st_q, vhi_q, pf0_q, pf1_q;

  assign launch = start && !busy;

  ae_seq_timer #(.TOTAL(TOTAL_CLKS), .SW(SW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy),
    .step   (step),
    .finish (finish)
  );

  ae_bus_plan #(
    .ACC_CLKS (ACC_CLKS),
    .IDLE_PRE (IDLE_PRE),
    .IDLE_MID (IDLE_MID),
    .SW       (SW)
  ) u_plan (
    .busy      (busy),
    .step      (step),
    .kind      (kind),
    .slot      (slot),
    .beat_last (beat_last)
  );

  ae_frame_mux #(
    .AW       (AW),
    .DW       (DW),
    .FCW      (FCW),
    .VEC_BASE (VEC_BASE),
    .FC_DATA  (FC_DATA),
    .FC_PROG  (FC_PROG)
  ) u_mux (
    .kind    (kind),
    .slot    (slot),
    .pc_snap (pc_q),
    .sr_snap (sr_q),
    .ir_snap (ir_q),
    .fa_snap (fa_q),
    .st_snap (st_q),
    .ssp_new (ssp_q),
    .pc_cur  (pc_q),
    .act     (bus_act),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .fc      (bus_fc)
  );

  // Snapshot at launch; read data captured on the last clock of each read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      fa_q  <= '0;
      ssp_q <= '0;
      sr_q  <= '0;
      ir_q  <= '0;
      st_q  <= '0;
      vhi_q <= '0;
      pf0_q <= '0;
      pf1_q <= '0;
    end else if (launch) begin
      pc_q  <= pc_in;
      fa_q  <= fault_addr;
      sr_q  <= sr_in;
      ir_q  <= ir_in;
      st_q  <= stat_word;
      ssp_q <= ssp_in - AW'(FRAME_BYTES);
    end else if (beat_last && kind != ACC_STACK) begin
      if (slot == VEC_HI_SLOT)      vhi_q <= bus_rdata;
      else if (slot == VEC_LO_SLOT) pc_q  <= {vhi_q, bus_rdata};
      else if (slot == PF_LO_SLOT)  pf0_q <= bus_rdata;
      else if (slot == PF_HI_SLOT)  pf1_q <= bus_rdata;
    end
  end

  assign ssp_out  = ssp_q;
  assign pc_out   = pc_q;
  assign pf_word0 = pf0_q;
  assign pf_word1 = pf1_q;

endmodule

// File: rtl/ae_frame_seq_chk.sv
module ae_frame_seq_chk #(
  parameter int             TOTAL       = 50,
  parameter int             IDLE_PRE    = 4,
  parameter int             FETCH_FROM  = 40,
  parameter int             AW          = 32,
  parameter int             FCW         = 3,
  parameter int             FRAME_BYTES = 14,
  parameter logic [FCW-1:0] FC_DATA     = 3'd5,
  parameter logic [FCW-1:0] FC_PROG     = 3'd6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           bus_act,
  input logic           bus_wr,
  input logic [FCW-1:0] bus_fc,
  input logic [AW-1:0]  ssp_in,
  input logic [AW-1:0]  ssp_out
);

  localparam int CW = $clog2(TOTAL + 2);

  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cyc <= '0;
    else if (busy) cyc <= cyc + 1'b1;
    else           cyc <= '0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc == CW'(TOTAL));  // R1
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cyc < CW'(TOTAL));  // R1
  AST_LEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc < CW'(IDLE_PRE)) |-> !bus_act);  // R2
  AST_STACK_FC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && bus_wr) |-> bus_fc == FC_DATA);  // R4
  AST_FETCH_FC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && cyc >= CW'(FETCH_FROM)) |-> (!bus_wr && bus_fc == FC_PROG));  // R6
  AST_SSP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ssp_out == $past(ssp_in) - AW'(FRAME_BYTES));  // R7
  AST_SSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ssp_out));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_act);  // R9

endmodule

bind ae_frame_seq ae_frame_seq_chk #(
  .TOTAL       (TOTAL_CLKS),
  .IDLE_PRE    (IDLE_PRE),
  .FETCH_FROM  (FETCH_FROM),
  .AW          (AW),
  .FCW         (FCW),
  .FRAME_BYTES (FRAME_BYTES),
  .FC_DATA     (FC_DATA),
  .FC_PROG     (FC_PROG)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .bus_act (bus_act),
  .bus_wr  (bus_wr),
  .bus_fc  (bus_fc),
  .ssp_in  (ssp_in),
  .ssp_out (ssp_out)
);

// File: tb/tb_ae_frame_seq.sv
`timescale 1ns/1ps
module tb_ae_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] pc_in, fault_addr, ssp_in;
  logic [15:0] sr_in, ir_in, stat_word, bus_rdata;
  logic        busy, bus_act, bus_wr;
  logic [31:0] bus_addr, ssp_out, pc_out;
  logic [15:0] bus_wdata, pf_word0, pf_word1;
  logic [2:0]  bus_fc;

  always #2.5 clk = ~clk;

  ae_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .sr_in(sr_in),
    .ir_in(ir_in), .fault_addr(fault_addr), .stat_word(stat_word),
    .ssp_in(ssp_in), .bus_rdata(bus_rdata), .busy(busy), .bus_act(bus_act),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_fc(bus_fc), .ssp_out(ssp_out), .pc_out(pc_out),
    .pf_word0(pf_word0), .pf_word1(pf_word1)
  );

  // Memory model: vector words are set per run, other words follow the address.
  logic [15:0] vec_hi, vec_lo;
  function automatic logic [15:0] mem_word(input logic [31:0] a);
    if (a == 32'd12)      return vec_hi;
    else if (a == 32'd14) return vec_lo;
    else                  return a[16:1] ^ 16'h6B2D;
  endfunction
  always_comb bus_rdata = mem_word(bus_addr);

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] actual, input logic [31:0] expect_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, actual, expect_v);
    end
  endtask

  typedef struct {
    bit          act;
    bit          wr;
    logic [31:0] addr;
    logic [15:0] d;
    logic [2:0]  fc;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic push(input int n, input bit act, input bit wr,
                      input logic [31:0] addr, input logic [15:0] d,
                      input logic [2:0] fc, input string tag);
    exp_t e;
    e.act = act; e.wr = wr; e.addr = addr; e.d = d; e.fc = fc; e.tag = tag;
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic run(input logic [31:0] pc, input logic [15:0] sr,
                     input logic [15:0] ir, input logic [31:0] fa,
                     input logic [15:0] st, input logic [31:0] ssp,
                     input logic [31:0] handler, input bit repulse);
    int offs[7];
    logic [15:0] words[7];
    logic [31:0] nssp;
    offs  = '{2, 6, 4, 8, 10, 14, 12};
    words = '{pc[15:0], sr, pc[31:16], ir, fa[15:0], st, fa[31:16]};
    nssp  = ssp - 32'd14;
    vec_hi = handler[31:16];
    vec_lo = handler[15:0];
    q.delete();
    push(4, 0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 7; k++)
      push(4, 1, 1, ssp - 32'(offs[k]), words[k], 3'd5, "R3");
    push(4, 1, 0, 32'd12, 0, 3'd5, "R5");
    push(4, 1, 0, 32'd14, 0, 3'd5, "R5");
    push(4, 1, 0, handler, 0, 3'd6, "R6");
    push(2, 0, 0, 0, 0, 0, "R6");
    push(4, 1, 0, handler + 32'd2, 0, 3'd6, "R6");

    @(negedge clk);
    pc_in = pc; sr_in = sr; ir_in = ir; fault_addr = fa;
    stat_word = st; ssp_in = ssp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      check(busy == 1'b1, "R1", "busy during sequence", 32'(busy), 32'd1);
      check(bus_act == q[i].act, q[i].tag, "bus_act", 32'(bus_act), 32'(q[i].act));
      if (q[i].act) begin
        check(bus_wr == q[i].wr, "R4", "bus_wr", 32'(bus_wr), 32'(q[i].wr));
        check(bus_addr == q[i].addr, q[i].tag, "bus_addr", bus_addr, q[i].addr);
        check(bus_fc == q[i].fc, "R4", "bus_fc", 32'(bus_fc), 32'(q[i].fc));
        if (q[i].wr)
          check(bus_wdata == q[i].d, q[i].tag, "bus_wdata", 32'(bus_wdata), 32'(q[i].d));
      end
      check(ssp_out == nssp, "R7", "ssp_out", ssp_out, nssp);
      if (repulse && i == 10) begin
        start = 1'b1;          // R8: second request while busy
        pc_in = ~pc; ssp_in = ssp ^ 32'h0F0F_0F00; sr_in = ~sr;
        fault_addr = ~fa;
      end
      if (repulse && i == 11) start = 1'b0;
      @(negedge clk);
    end
    check(busy == 1'b0, "R1", "busy after 50 clocks", 32'(busy), 32'd0);
    check(pc_out == handler, "R5", "pc_out", pc_out, handler);
    check(pf_word0 == mem_word(handler), "R6", "pf_word0",
          32'(pf_word0), 32'(mem_word(handler)));
    check(pf_word1 == mem_word(handler + 32'd2), "R6", "pf_word1",
          32'(pf_word1), 32'(mem_word(handler + 32'd2)));
    check(ssp_out == nssp, repulse ? "R8" : "R7", "ssp_out after run", ssp_out, nssp);
    check(bus_act == 1'b0, "R9", "bus_act after run", 32'(bus_act), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    pc_in = '0; sr_in = '0; ir_in = '0; fault_addr = '0; stat_word = '0; ssp_in = '0;
    vec_hi = '0; vec_lo = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "busy in reset", 32'(busy), 32'd0);
    check(bus_act == 1'b0, "R9", "bus_act in reset", 32'(bus_act), 32'd0);
    check(ssp_out == 32'd0, "R9", "ssp_out in reset", ssp_out, 32'd0);
    check(pc_out == 32'd0, "R9", "pc_out in reset", pc_out, 32'd0);
    check(pf_word0 == 16'd0 && pf_word1 == 16'd0, "R9", "prefetch in reset",
          {pf_word0, pf_word1}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_act == 1'b0, "R9", "bus_act idle", 32'(bus_act), 32'd0);

    run(32'd3072, 16'h2701, 16'hB74C, 32'd900360119, 16'd26551, 32'd2048,
        32'h0000_1400, 1'b0);
    run(32'hDEAD_BEE1, 16'h0F1E, 16'h4E71, 32'hC001_D00D, 16'h0015, 32'h0000_000C,
        32'hFFFF_FFFE, 1'b0);
    run(32'h0012_3456, 16'h2000, 16'h3A5C, 32'h0040_0003, 16'h1234, 32'h0008_0000,
        32'h0000_8000, 1'b1);
    run(32'h7654_3210, 16'hA5A5, 16'h5A5A, 32'h0000_0101, 16'hFFFF, 32'h0001_0000,
        32'h0123_4566, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule